// File: doc/BRIEF.md
# Queue Status Interrupt Source Selector

This block turns the status flags of a bank of 64 hardware queues into interrupt requests. The queues fall into two groups. Each queue of the lower group (queues 0..31) reports four flags: empty, nearly empty, nearly full and full. Each queue of the upper group (queues 32..63) reports only nearly empty to this block. For every lower queue, software picks one of eight trigger conditions: one of the four flags, or the inverse of one of them. Every upper queue always triggers on its nearly-empty flag.

A triggered condition sets a sticky interrupt bit only when that queue's enable bit is set. Software clears a sticky bit by writing 1 to it. Each group drives one interrupt line. The line is high while any of that group's interrupt bits is set together with its enable bit.

Software uses a simple word-wide register port. Besides whole-word writes to the select registers, a field-write command updates a single queue's select field. When that command targets queue 0, it leaves the neighbouring global control bit untouched. The block has no state machine. Every register updates in a single cycle from its next-state logic.

Top module: `qsis_top`

## Requirements
- R1: After reset, the select words, the global control bit and both enable registers are 0, both interrupt registers read 0xFFFFFFFF, and both interrupt lines are low.
- R2: A lower queue's status nibble in `lo_stat[4q+3:4q]` holds empty in bit 0, nearly empty in bit 1, nearly full in bit 2 and full in bit 3. The 3-bit select codes are: 0 empty, 1 nearly empty, 2 nearly full, 3 full, and 4..7 the inverses of 0..3. An inverse code fires while its flag is 0.
- R3: Lower queue q's select field is the nibble at bits 4*(q%8)+3 down to 4*(q%8) of select word q/8, at addresses 0..3. Only the low 3 bits of the nibble form the code. Bit 3 of each nibble plays no part in the selection.
- R4: The trigger condition of upper queue 32+k is `hi_ne[k]`.
- R5: An interrupt bit is set at a clock edge when its condition is true and its enable bit is set. Interrupt registers are at address 7 (lower) and 8 (upper). Enables are at address 5 (lower) and 6 (upper), bit k for the group's queue k. With the enable clear, nothing sets the bit. A set bit stays set after the condition goes away.
- R6: Writing an interrupt register clears each bit written with 1 and keeps each bit written with 0. If the condition and the enable of a bit are both still true at that edge, the bit stays set.
- R7: `irq_lo` and `irq_hi` are each the OR of their group's interrupt bits masked by that group's enable bits.
- R8: A write to address 4 is a field write, with the queue id in wdata[5:0] and the code in wdata[10:8]. For queue 0 it replaces the nibble's low 3 bits and keeps bit 3. For queues 1..31 it writes the code into the nibble with bit 3 cleared. Ids 32..63 have no effect.
- R9: The global control bit is bit 3 of select word 0 and drives `aux_ctl`. A whole-word write to address 0 sets or clears it.
- R10: A read presents its data on `reg_rdata` one cycle after `reg_rd`. Address 4 and addresses 9..15 read as 0, and writes to addresses 9..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| lo_stat | input | 128 | Status nibbles of the lower queues |
| hi_ne | input | 32 | Nearly-empty flags of the upper queues |
| irq_lo | output | 1 | Lower-group interrupt line |
| irq_hi | output | 1 | Upper-group interrupt line |
| aux_ctl | output | 1 | Global control bit held in select word 0 |

## Verification
The bench uses a write-1-to-clear while the condition still holds, and expects the bit to stay set. A design that let the clear win would lose that interrupt. A queue is given a select nibble with bit 3 set, and it must still decode as its 3-bit code. A design that used all four bits would pick the wrong condition. Field writes to queue 0 must keep the global control bit, and field writes with an upper-group id must leave every select word unchanged. The bench also checks that a pending bit with its enable cleared keeps the line low, and that an upper queue's bit stays set after its nearly-empty flag falls.

// File: rtl/qsis_pkg.sv
package qsis_pkg;

    localparam int ADDR_W = 4;
    localparam int CODE_W = 3;
    localparam int NIB_W  = 4;

    // register word addresses; select words occupy 0 .. (number of words - 1)
    localparam logic [ADDR_W-1:0] A_FIELD  = 4'd4;
    localparam logic [ADDR_W-1:0] A_EN_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] A_EN_HI  = 4'd6;
    localparam logic [ADDR_W-1:0] A_INT_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_INT_HI = 4'd8;

    // field-write command layout
    localparam int FLD_CODE_LSB = 8;

    typedef enum logic [CODE_W-1:0] {
        SRC_EMPTY      = 3'd0,
        SRC_NEAR_EMPTY = 3'd1,
        SRC_NEAR_FULL  = 3'd2,
        SRC_FULL       = 3'd3,
        SRC_NOT_EMPTY  = 3'd4,
        SRC_NOT_NEMPTY = 3'd5,
        SRC_NOT_NFULL  = 3'd6,
        SRC_NOT_FULL   = 3'd7
    } src_code_e;

    // low two code bits pick the flag, the top bit inverts it
    function automatic logic src_hit(input logic [NIB_W-1:0] flags,
                                     input logic [CODE_W-1:0] code);
        return flags[code[1:0]] ^ code[2];
    endfunction

endpackage

// File: rtl/qsis_sel_regs.sv
module qsis_sel_regs
    import qsis_pkg::*;
#(
    parameter int LO_Q  = 32,
    parameter int DW    = 32,
    parameter int QID_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DW-1:0]           wdata,
    output logic [LO_Q*NIB_W-1:0]   sel_flat,
    output logic                    aux_ctl
);
    localparam int NSEL = (LO_Q * NIB_W) / DW;

    logic [LO_Q*NIB_W-1:0] sel_q;
    logic [LO_Q*NIB_W-1:0] sel_d;
    logic [QID_W-1:0]      fld_qid;
    logic [CODE_W-1:0]     fld_code;
    logic                  fld_wr;

    assign fld_qid  = wdata[QID_W-1:0];
    assign fld_code = wdata[FLD_CODE_LSB +: CODE_W];
    assign fld_wr   = wr && (addr == A_FIELD);

    always_comb begin
        sel_d = sel_q;
        if (wr) begin
            for (int w = 0; w < NSEL; w++) begin
                if (addr == ADDR_W'(w)) begin
                    sel_d[w*DW +: DW] = wdata;
                end
            end
        end
        // field write reaches only lower-group ids (top id bit clear)
        if (fld_wr && !fld_qid[QID_W-1]) begin
            for (int q = 0; q < LO_Q; q++) begin
                if (fld_qid[QID_W-2:0] == (QID_W-1)'(q)) begin
                    if (q == 0) begin
                        sel_d[CODE_W-1:0] = fld_code;
                    end else begin
                        sel_d[q*NIB_W +: NIB_W] = {1'b0, fld_code};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_flat = sel_q;
    assign aux_ctl  = sel_q[NIB_W-1];

    assert_fld_keeps_aux_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fld_wr |=> $stable(aux_ctl));

    assert_fld_upper_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_wr && fld_qid[QID_W-1]) |=> $stable(sel_q));

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr > A_INT_HI) |=> $stable(sel_q));

endmodule

// File: rtl/qsis_cond.sv
module qsis_cond
    import qsis_pkg::*;
#(
    parameter int LO_Q = 32,
    parameter int HI_Q = 32
) (
    input  logic [LO_Q*NIB_W-1:0] lo_stat,
    input  logic [LO_Q*NIB_W-1:0] sel_flat,
    input  logic [HI_Q-1:0]       hi_ne,
    output logic [LO_Q-1:0]       cond_lo,
    output logic [HI_Q-1:0]       cond_hi
);
    for (genvar q = 0; q < LO_Q; q++) begin : g_lo
        assign cond_lo[q] = src_hit(lo_stat[q*NIB_W +: NIB_W],
                                    sel_flat[q*NIB_W +: CODE_W]);
    end

    // upper group trigger is fixed to nearly empty
    assign cond_hi = hi_ne;

endmodule

// File: rtl/qsis_sticky.sv
module qsis_sticky #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= RST_VAL;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/qsis_top.sv
module qsis_top
    import qsis_pkg::*;
#(
    parameter int LO_Q  = 32,
    parameter int HI_Q  = 32,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic [LO_Q*NIB_W-1:0] lo_stat,
    input  logic [HI_Q-1:0]       hi_ne,
    output logic                  irq_lo,
    output logic                  irq_hi,
    output logic                  aux_ctl
);
    localparam int QID_W = $clog2(LO_Q + HI_Q);
    localparam int NSEL  = (LO_Q * NIB_W) / DW;

    logic [LO_Q*NIB_W-1:0] sel_flat;
    logic [LO_Q-1:0]       cond_lo;
    logic [HI_Q-1:0]       cond_hi;
    logic [LO_Q-1:0]       en_lo;
    logic [HI_Q-1:0]       en_hi;
    logic [LO_Q-1:0]       int_lo;
    logic [HI_Q-1:0]       int_hi;
    logic [LO_Q-1:0]       clr_lo;
    logic [HI_Q-1:0]       clr_hi;
    logic [DW-1:0]         rd_mux;

    qsis_sel_regs #(.LO_Q(LO_Q), .DW(DW), .QID_W(QID_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .sel_flat (sel_flat),
        .aux_ctl  (aux_ctl)
    );

    qsis_cond #(.LO_Q(LO_Q), .HI_Q(HI_Q)) u_cond (
        .lo_stat  (lo_stat),
        .sel_flat (sel_flat),
        .hi_ne    (hi_ne),
        .cond_lo  (cond_lo),
        .cond_hi  (cond_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_lo <= '0;
            en_hi <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_EN_LO) en_lo <= reg_wdata[LO_Q-1:0];
            if (reg_addr == A_EN_HI) en_hi <= reg_wdata[HI_Q-1:0];
        end
    end

    assign clr_lo = (reg_wr && reg_addr == A_INT_LO) ? reg_wdata[LO_Q-1:0] : '0;
    assign clr_hi = (reg_wr && reg_addr == A_INT_HI) ? reg_wdata[HI_Q-1:0] : '0;

    qsis_sticky #(.W(LO_Q), .RST_VAL({LO_Q{1'b1}})) u_int_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cond_lo & en_lo),
        .clr_vec (clr_lo),
        .flags   (int_lo)
    );

    qsis_sticky #(.W(HI_Q), .RST_VAL({HI_Q{1'b1}})) u_int_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cond_hi & en_hi),
        .clr_vec (clr_hi),
        .flags   (int_hi)
    );

    assign irq_lo = |(int_lo & en_lo);
    assign irq_hi = |(int_hi & en_hi);

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NSEL; w++) begin
            if (reg_addr == ADDR_W'(w)) rd_mux = sel_flat[w*DW +: DW];
        end
        unique case (reg_addr)
            A_EN_LO:  rd_mux[LO_Q-1:0] = en_lo;
            A_EN_HI:  rd_mux[HI_Q-1:0] = en_hi;
            A_INT_LO: rd_mux[LO_Q-1:0] = int_lo;
            A_INT_HI: rd_mux[HI_Q-1:0] = int_hi;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    assert_irq_quiet_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo == '0) |-> !irq_lo);

    assert_irq_quiet_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi == '0) |-> !irq_hi);

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr > A_INT_HI) |=> (reg_rdata == '0));

    assert_upper_follows_ne_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_ne & en_hi) != '0) |=> ((int_hi & $past(hi_ne & en_hi)) == $past(hi_ne & en_hi)));

endmodule

// File: tb/qsis_top_tb.sv
module qsis_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] lo_stat = '0;
    logic [31:0]  hi_ne = '0;
    logic         irq_lo;
    logic         irq_hi;
    logic         aux_ctl;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        prev_rd = 1'b0;

    always #5 clk = ~clk;

    qsis_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lo_stat(lo_stat), .hi_ne(hi_ne), .irq_lo(irq_lo), .irq_hi(irq_hi),
        .aux_ctl(aux_ctl)
    );

    // monitor: read data is valid one cycle after the strobe
    always @(negedge clk) begin
        if (prev_rd) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
            end
        end
        prev_rd = reg_rd;
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        @(negedge clk);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", t, act, e);
        end
    endtask

    task automatic fld(input int qid, input int code);
        wr(4'd4, (32'(code) << 8) | 32'(qid));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (R1..R10 run incomplete)");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_bit(aux_ctl, 1'b0, "R1 aux_ctl after reset");
        chk_bit(irq_lo, 1'b0, "R1 irq_lo after reset");
        chk_bit(irq_hi, 1'b0, "R1 irq_hi after reset");
        rd(4'd0, 32'h0, "R1 select word 0");
        rd(4'd1, 32'h0, "R1 select word 1");
        rd(4'd3, 32'h0, "R1 select word 3");
        rd(4'd5, 32'h0, "R1 lower enables");
        rd(4'd6, 32'h0, "R1 upper enables");
        rd(4'd7, 32'hFFFF_FFFF, "R1 lower interrupts");
        rd(4'd8, 32'hFFFF_FFFF, "R1 upper interrupts");

        // R6 write-1-to-clear with no enables
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd7, 32'h0, "R6 lower cleared");
        rd(4'd8, 32'h0, "R6 upper cleared");

        // R9 global control bit through word write
        wr(4'd0, 32'h0000_0008);
        chk_bit(aux_ctl, 1'b1, "R9 aux_ctl set by word write");
        rd(4'd0, 32'h0000_0008, "R9 select word 0 readback");

        // R8 field writes
        fld(0, 5);
        chk_bit(aux_ctl, 1'b1, "R8 aux_ctl kept by queue 0 field write");
        rd(4'd0, 32'h0000_000D, "R8 queue 0 field");
        fld(5, 2);
        rd(4'd0, 32'h0020_000D, "R8 queue 5 field");
        fld(40, 7);
        rd(4'd0, 32'h0020_000D, "R8 upper id ignored");

        // R3 nibble bit 3 ignored: queue 9 nibble 0xC decodes as not-empty
        wr(4'd1, 32'h0000_00C0);
        wr(4'd5, 32'h0000_0320);
        idle(2);
        rd(4'd7, 32'h0000_0200, "R3/R2 inverse code fires, R5 disabled queue 0 stays clear");
        chk_bit(irq_lo, 1'b1, "R7 irq_lo high");

        // R2 flags on, R5 sticky
        lo_stat[36] = 1'b1;
        lo_stat[22] = 1'b1;
        idle(2);
        rd(4'd7, 32'h0000_0220, "R5 sticky plus near-full");

        // R6 clear while condition persists
        wr(4'd7, 32'h0000_0220);
        rd(4'd7, 32'h0000_0020, "R6 set wins over clear");
        lo_stat[22] = 1'b0;
        idle(1);
        wr(4'd7, 32'h0000_0020);
        rd(4'd7, 32'h0, "R6 cleared after condition gone");
        chk_bit(irq_lo, 1'b0, "R7 irq_lo low");

        // R2 full and nearly-empty codes
        fld(8, 3);
        fld(5, 1);
        lo_stat[35] = 1'b1;
        lo_stat[21] = 1'b1;
        idle(2);
        rd(4'd7, 32'h0000_0120, "R2 full and nearly-empty codes");
        rd(4'd1, 32'h0000_00C3, "R8 queue 8 field in word 1");
        rd(4'd0, 32'h0010_000D, "R8 queue 5 rewrite clears nibble bit 3");

        // R7 masked by enables
        wr(4'd5, 32'h0);
        chk_bit(irq_lo, 1'b0, "R7 irq_lo masked by enables");
        rd(4'd7, 32'h0000_0120, "R7 pending bits kept");

        // R4 upper group
        hi_ne[3] = 1'b1;
        hi_ne[7] = 1'b1;
        wr(4'd6, 32'h0000_0008);
        idle(2);
        rd(4'd8, 32'h0000_0008, "R4 upper nearly-empty");
        chk_bit(irq_hi, 1'b1, "R7 irq_hi high");
        hi_ne[3] = 1'b0;
        idle(2);
        rd(4'd8, 32'h0000_0008, "R5 upper sticky");
        wr(4'd8, 32'h0000_0008);
        rd(4'd8, 32'h0, "R6 upper cleared");
        chk_bit(irq_hi, 1'b0, "R7 irq_hi low");

        // R10 unmapped space
        wr(4'd13, 32'hFFFF_FFFF);
        rd(4'd0, 32'h0010_000D, "R10 unmapped write harmless");
        rd(4'd13, 32'h0, "R10 unmapped read");
        rd(4'd4, 32'h0, "R10 field address reads zero");

        idle(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule